// File: doc/BRIEF.md
# Self-Checking 8-bit S-box with Swapped-Nibble Recomputation

This block performs an 8-bit involutive substitution built from two identical 4-bit substitution cells placed between a bit permutation and its inverse. The permutation is one generic parameter, so one netlist covers any of the byte-wide variants that differ only in bit wiring.

Each lookup runs twice on the same two physical 4-bit cells. In the first pass the upper nibble of the permuted byte enters cell A and the lower nibble enters cell B. In the second pass the nibbles trade cells, and the cell outputs are traded back. The two passes are then compared. A cell that is stuck, or that is hit by a transient during either pass, produces a mismatch and raises the error flag. The result delivered is the first-pass value. For test, a stuck-at override can be forced on the output of cell A.

Top module: `resi_sbox8`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `done_o` and `err_o` are 0 and `result_o` is 0x00.
- R2: The result follows these rules. Permuted bit i equals `data_i[P[i]]`, where P = {1,4,7,2,5,0,3,6} for i = 0..7 (parameter digits from most to least significant are P[7]..P[0]). Bits 7:4 of the permuted byte go to cell A and bits 3:0 go to cell B. Each cell maps 0..F to 1,0,5,3,E,2,F,7,D,A,9,B,C,8,4,6. The cell A output forms bits 7:4 of q and the cell B output forms bits 3:0. Then `result_o[P[i]] = q[i]`.
- R3: With no fault forced, applying the block to its own result returns the original byte for all 256 inputs.
- R4: Suppose `start_i` is sampled high in idle at clock edge k. Then `done_o`, `result_o` and `err_o` for that input appear after edge k+2, and `done_o` stays high for exactly one cycle.
- R5: A `start_i` sampled at edges k+1 or k+2 is ignored. It produces no extra `done_o`, and it does not change the result of the operation in flight.
- R6: With `fault_mask_i` = 0 throughout an operation, `err_o` is 0.
- R7: A set bit of `fault_mask_i` forces the matching bit of cell A's output to the matching bit of `fault_val_i`. `err_o` is 1 exactly when this override changes cell A's output on the upper nibble (first pass) or on the lower nibble (second pass). `result_o` then carries the forced first-pass upper nibble.
- R8: `result_o` and `err_o` keep their values from the cycle `done_o` rises until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a lookup of `data_i` when idle |
| data_i | input | 8 | Byte to substitute, sampled with `start_i` |
| fault_mask_i | input | 4 | Bits of cell A's output to force |
| fault_val_i | input | 4 | Values forced on masked bits |
| done_o | output | 1 | One-cycle pulse: result and flag are ready |
| result_o | output | 8 | Substituted byte |
| err_o | output | 1 | Mismatch between the two passes |

## Verification
Every result and error flag is due on the third clock edge after the bench drives `start_i`. That is, the edge that samples the start plus two pass edges. The driver stamps each expected item with that edge count before pushing it into the scoreboard queue. The monitor samples on the falling edge and pops an item only when `done_o` is high. It checks the value, the flag and the stamped edge number, and it treats any `done_o` that arrives with no pending item as a failure. Starts given in the two busy cycles, and the quiet cycles after an operation, are observed through that same path, so a stray pulse or a drifting output cannot go unnoticed.

// File: rtl/resi_sbox_pkg.sv
package resi_sbox_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } pair_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    function automatic nib_t nib_lookup(input nib_t a);
        nib_t r;
        case (a)
            4'h0: r = 4'h1;  4'h1: r = 4'h0;  4'h2: r = 4'h5;  4'h3: r = 4'h3;
            4'h4: r = 4'he;  4'h5: r = 4'h2;  4'h6: r = 4'hf;  4'h7: r = 4'h7;
            4'h8: r = 4'hd;  4'h9: r = 4'ha;  4'ha: r = 4'h9;  4'hb: r = 4'hb;
            4'hc: r = 4'hc;  4'hd: r = 4'h8;  4'he: r = 4'h4;  default: r = 4'h6;
        endcase
        return r;
    endfunction

    function automatic pair_t swap_pair(input pair_t p);
        pair_t r;
        r.hi = p.lo;
        r.lo = p.hi;
        return r;
    endfunction

endpackage

// File: rtl/resi_sbox_bitperm.sv
module resi_sbox_bitperm
    import resi_sbox_pkg::*;
#(
    parameter logic [IDX_W*BYTE_W-1:0] PERM   = 24'o63052741,
    parameter bit                      INVERT = 1'b0
) (
    input  byte_t d,
    output byte_t q
);

    // Entry i of PERM names the source bit of permuted bit i.
    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            localparam int SRC = int'(PERM[IDX_W*i +: IDX_W]);
            if (INVERT) begin : g_inv
                assign q[SRC] = d[i];
            end else begin : g_fwd
                assign q[i] = d[SRC];
            end
        end
    endgenerate

endmodule

// File: rtl/resi_sbox_nib.sv
module resi_sbox_nib
    import resi_sbox_pkg::*;
(
    input  nib_t a,
    input  nib_t stuck_mask,
    input  nib_t stuck_val,
    output nib_t y
);

    nib_t raw;

    assign raw = nib_lookup(a);
    assign y   = (raw & ~stuck_mask) | (stuck_val & stuck_mask);

endmodule

// File: rtl/resi_sbox8.sv
module resi_sbox8
    import resi_sbox_pkg::*;
#(
    parameter logic [IDX_W*BYTE_W-1:0] PERM = 24'o63052741
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [BYTE_W-1:0]   data_i,
    input  logic [NIB_W-1:0]    fault_mask_i,
    input  logic [NIB_W-1:0]    fault_val_i,
    output logic                done_o,
    output logic [BYTE_W-1:0]   result_o,
    output logic                err_o
);

    phase_e phase;
    byte_t  in_q;
    pair_t  perm_in;
    pair_t  feed;
    pair_t  cell_out;
    pair_t  back;
    pair_t  first_q;
    pair_t  res_q;
    logic   second;

    resi_sbox_bitperm #(.PERM(PERM), .INVERT(1'b0)) u_perm_in (
        .d (in_q),
        .q (perm_in)
    );

    assign second = (phase == PH_SECOND);
    assign feed   = second ? swap_pair(perm_in) : perm_in;

    // Cell A carries the test override; cell B is always clean.
    resi_sbox_nib u_cell_a (
        .a          (feed.hi),
        .stuck_mask (fault_mask_i),
        .stuck_val  (fault_val_i),
        .y          (cell_out.hi)
    );

    resi_sbox_nib u_cell_b (
        .a          (feed.lo),
        .stuck_mask ('0),
        .stuck_val  ('0),
        .y          (cell_out.lo)
    );

    assign back = second ? swap_pair(cell_out) : cell_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            in_q    <= '0;
            first_q <= '0;
            res_q   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        in_q  <= data_i;
                        phase <= PH_FIRST;
                    end
                end
                PH_FIRST: begin
                    first_q <= back;
                    phase   <= PH_SECOND;
                end
                PH_SECOND: begin
                    res_q  <= first_q;
                    err_o  <= (back != first_q);
                    done_o <= 1'b1;
                    phase  <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    resi_sbox_bitperm #(.PERM(PERM), .INVERT(1'b1)) u_perm_out (
        .d (res_q),
        .q (result_o)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

    AST_DONE_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND) |=> done_o); // R4

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST) |=> (phase == PH_SECOND)); // R5

    AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(fault_mask_i) == '0 && $past(fault_mask_i, 2) == '0)
        |-> !err_o); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(err_o))); // R8

endmodule

// File: tb/resi_sbox8_test.sv
module resi_sbox8_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] data_i = '0;
    logic [3:0] fault_mask_i = '0;
    logic [3:0] fault_val_i = '0;
    logic       done_o;
    logic [7:0] result_o;
    logic       err_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       err;
        int         due;
    } exp_t;

    exp_t sb_q[$];

    resi_sbox8 uut (
        .clk (clk), .rst (rst), .start_i (start_i), .data_i (data_i),
        .fault_mask_i (fault_mask_i), .fault_val_i (fault_val_i),
        .done_o (done_o), .result_o (result_o), .err_o (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Spec model (R2, R7)
    function automatic logic [3:0] tbl(input logic [3:0] a);
        logic [3:0] t [16] = '{4'h1,4'h0,4'h5,4'h3,4'he,4'h2,4'hf,4'h7,
                               4'hd,4'ha,4'h9,4'hb,4'hc,4'h8,4'h4,4'h6};
        return t[a];
    endfunction

    function automatic logic [8:0] model(input logic [7:0] x,
                                         input logic [3:0] m,
                                         input logic [3:0] v);
        int pe [8] = '{1,4,7,2,5,0,3,6};
        logic [7:0] p, q, y;
        logic [3:0] shi, slo, fhi, flo;
        for (int i = 0; i < 8; i++) p[i] = x[pe[i]];
        shi = tbl(p[7:4]);
        slo = tbl(p[3:0]);
        fhi = (shi & ~m) | (v & m);
        flo = (slo & ~m) | (v & m);
        q = {fhi, slo};
        for (int i = 0; i < 8; i++) y[pe[i]] = q[i];
        return {((fhi != shi) || (flo != slo)), y};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on done
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o && done_prev)
                check("R4 done pulse width", 32'd2, 32'd1);
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    check("R5 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check("R2/R7 result", {24'd0, result_o}, {24'd0, e.res});
                    check("R6/R7 err", {31'd0, err_o}, {31'd0, e.err});
                    check("R4 latency", cyc, e.due);
                end
            end
            done_prev <= done_o;
        end
    end

    task automatic do_op(input logic [7:0] x, input bit poke,
                         output logic [7:0] y);
        logic [8:0] m;
        exp_t e;
        @(negedge clk);
        m = model(x, fault_mask_i, fault_val_i);
        e.res = m[7:0];
        e.err = m[8];
        e.due = cyc + 3;
        sb_q.push_back(e);
        data_i  = x;
        start_i = 1'b1;
        @(negedge clk);
        start_i = poke;           // R5: busy-cycle starts
        data_i  = ~x;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        y = result_o;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check("watchdog", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] y, z, hold_r;
        logic       hold_e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 done", {31'd0, done_o}, 32'd0);
        check("R1 err", {31'd0, err_o}, 32'd0);
        check("R1 result", {24'd0, result_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after release", {24'd0, result_o}, 32'd0);

        // R2: directed patterns
        do_op(8'h00, 1'b0, y);
        do_op(8'hff, 1'b0, y);
        do_op(8'ha5, 1'b0, y);
        do_op(8'h3c, 1'b0, y);

        // R5: starts during busy cycles are ignored
        do_op(8'h5a, 1'b1, y);
        do_op(8'h81, 1'b1, y);

        // R8: outputs hold while idle
        hold_r = result_o;
        hold_e = err_o;
        repeat (4) @(negedge clk);
        check("R8 result held", {24'd0, result_o}, {24'd0, hold_r});
        check("R8 err held", {31'd0, err_o}, {31'd0, hold_e});

        // R3, R6: involution over all inputs, no fault
        for (int x = 0; x < 256; x++) begin
            do_op(x[7:0], 1'b0, y);
            do_op(y, 1'b0, z);
            check("R3 involution", {24'd0, z}, {24'd0, x[7:0]});
        end

        // R7: stuck-at override on cell A
        for (int f = 0; f < 4; f++) begin
            fault_mask_i = 4'b0001 << f;
            fault_val_i  = (f % 2 == 0) ? 4'hf : 4'h0;
            for (int x = 0; x < 256; x += 17) do_op(x[7:0], 1'b0, y);
        end
        fault_mask_i = 4'hf;
        fault_val_i  = 4'h3;
        for (int x = 0; x < 256; x += 29) do_op(x[7:0], 1'b0, y);
        fault_mask_i = '0;
        fault_val_i  = '0;

        repeat (4) @(negedge clk);
        check("R4 scoreboard drained", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule